// File: doc/BRIEF.md
# Dual-Controller DMA Channel Register File

This block keeps the per-channel programming registers for a pair of cascaded four-channel DMA controllers. Each of the eight channels has a 16-bit base address, a 16-bit base count and a current position. The current position is a current address plus a transfer progress value. Software reaches these registers through a small I/O port bus. It gives a controller select and a 4-bit port offset and issues byte writes, word writes or byte reads. For each controller, one byte pointer decides whether an 8-bit access touches the low byte or the high byte of a 16-bit register.

Completing a load reloads the channel's current registers. A load completes either with the high byte or with a word write. The transfer side reports how far a channel has got through a progress strobe. A read-back then shows the moving address and the remaining count. The second controller handles wide (two-byte) transfers, so its decoded fields sit one port bit higher. Its internal positions are also kept at twice the programmed value.

Top module: `dmaregs_top`

## Requirements
- R1: After synchronous reset, all base registers, current addresses and progress values are zero, both byte pointers select the low byte, and rdData is 0.
- R2: With ctlSel=0, port bit 0 selects the register (0 = address, 1 = count) and port bits [2:1] give the channel.
- R3: With ctlSel=1, port bit 1 selects the register (0 = address, 1 = count), port bits [3:2] give the channel, and port bit 0 is ignored.
- R4: A byte write with the pointer low stores wrData[7:0] into the low byte and keeps the high byte, without a reload. A byte write with the pointer high stores wrData[7:0] into the high byte and then reloads the channel.
- R5: A word write (ioWord=1) stores all 16 bits of wrData, reloads the channel at once, and leaves the byte pointer unchanged.
- R6: A reload sets the channel's current address to the base address (shifted left by one on controller 1) and sets its progress to zero. This applies whichever of the two registers was written.
- R7: Every byte read and every byte write toggles the byte pointer of the addressed controller only. The other controller's pointer is untouched.
- R8: Reading the address register returns byte (current address + progress) >> (c + 8*p), where c is the controller number and p the pointer.
- R9: Reading the count register returns byte ((base count << c) - progress) >> (c + 8*p), computed modulo 2^17.
- R10: A progress strobe loads progVal into channel progChan (bit 2 = controller, bits [1:0] = channel). A reload of the same channel in the same cycle wins and leaves the progress at zero.
- R11: clrPtr and mstRst each force the selected controller's pointer to the low byte. This overrides a toggle in the same cycle.
- R12: rdData takes the read result on the clock edge that samples ioRd and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctlSel | input | 1 | Controller addressed by the access or strobe |
| port | input | 4 | Port offset within the controller |
| ioWr | input | 1 | Write strobe |
| ioWord | input | 1 | Write is 16-bit when set, byte otherwise |
| wrData | input | 16 | Write data |
| ioRd | input | 1 | Byte read strobe |
| clrPtr | input | 1 | Clear byte pointer of ctlSel controller |
| mstRst | input | 1 | Master reset of ctlSel controller pointer |
| progWr | input | 1 | Progress update strobe |
| progChan | input | 3 | Channel of the progress update |
| progVal | input | 17 | Progress value |
| rdData | output | 8 | Registered read byte |

## Verification
The assertions take for granted that a read and a write never arrive in the same cycle. This premise is itself checked as an input assumption. They also expect that port bits outside the decoded fields are don't-care. The bench drives each access for exactly one cycle, between falling edges, and never combines ioRd with ioWr. Same-cycle overlaps are applied only where a requirement defines the outcome: a clear with a read, and a reload with a progress update. Each sequence first puts the pointer into a known state with a clear or master reset, so expected bytes follow from the requirements alone.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  localparam int CHAN_W = 2;
  localparam int CTL_N  = 2;

  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic              wrWord;
    logic              reload;
    logic              rdEn;
    logic              ctl;
    logic [CHAN_W-1:0] chan;
    logic              regSel;
    logic              bytePtr;
  } regStb_t;
endpackage

// File: rtl/dmaregs_ctrl.sv
module dmaregs_ctrl
  import dmaregs_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctlSel,
  input  logic [PORT_W-1:0] port,
  input  logic              ioWr,
  input  logic              ioWord,
  input  logic              ioRd,
  input  logic              clrPtr,
  input  logic              mstRst,
  output regStb_t           stb
);
  logic [CTL_N-1:0] ptr;
  logic byteAcc;
  logic ptrClr;

  assign byteAcc = (ioWr && !ioWord) || ioRd;
  assign ptrClr  = clrPtr || mstRst;

  always_comb begin
    stb.ctl     = ctlSel;
    stb.bytePtr = ptr[ctlSel];
    if (ctlSel) begin
      stb.regSel = port[1];
      stb.chan   = port[CHAN_W+1:2];
    end else begin
      stb.regSel = port[0];
      stb.chan   = port[CHAN_W:1];
    end
    stb.wrWord = ioWr && ioWord;
    stb.wrLo   = ioWr && !ioWord && !ptr[ctlSel];
    stb.wrHi   = ioWr && !ioWord && ptr[ctlSel];
    stb.reload = stb.wrHi || stb.wrWord;
    stb.rdEn   = ioRd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ptrClr) begin
      ptr[ctlSel] <= 1'b0;
    end else if (byteAcc) begin
      ptr[ctlSel] <= ~ptr[ctlSel];
    end
  end

  // input premise: reads and writes never share a cycle
  a_in_no_rdwr: assert property (@(posedge clk) disable iff (rst)
    !(ioWr && ioRd));

  // R7: a byte access flips exactly one pointer, the addressed one
  a_r7_ptr_toggle: assert property (@(posedge clk) disable iff (rst)
    (byteAcc && !ptrClr) |=> ($countones(ptr ^ $past(ptr)) == 1) &&
                             (ptr[$past(ctlSel)] != $past(ptr[ctlSel])));

  // R11: clear strobes leave the selected pointer low
  a_r11_ptr_clear: assert property (@(posedge clk) disable iff (rst)
    ptrClr |=> !ptr[$past(ctlSel)]);

  // R5: word writes leave both pointers alone
  a_r5_word_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (ioWr && ioWord && !ptrClr) |=> $stable(ptr));
endmodule

// File: rtl/dmaregs_dp.sv
module dmaregs_dp
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  regStb_t             stb,
  input  logic [ADDR_W-1:0]   wrData,
  input  logic                progWr,
  input  logic [CHAN_W:0]     progChan,
  input  logic [ADDR_W:0]     progVal,
  output logic [7:0]          rdData
);
  localparam int POS_W  = ADDR_W + 1;
  localparam int NCH    = CTL_N << CHAN_W;
  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] baseA [NCH];
  logic [ADDR_W-1:0] baseC [NCH];
  logic [POS_W-1:0]  curA  [NCH];
  logic [POS_W-1:0]  prog  [NCH];

  logic [CHAN_W:0]   idx;
  logic [ADDR_W-1:0] oldBase, newBase, addrSrc;
  logic [POS_W-1:0]  cntScaled, rdVal, rdShift;
  logic              anyWr;

  assign idx   = {stb.ctl, stb.chan};
  assign anyWr = stb.wrLo || stb.wrHi || stb.wrWord;

  always_comb begin
    oldBase = stb.regSel ? baseC[idx] : baseA[idx];
    if (stb.wrWord)
      newBase = wrData;
    else if (stb.wrHi)
      newBase = {wrData[HI_W-1:0], oldBase[BYTE_W-1:0]};
    else
      newBase = {oldBase[ADDR_W-1:BYTE_W], wrData[BYTE_W-1:0]};
    addrSrc   = stb.regSel ? baseA[idx] : newBase;
    cntScaled = stb.ctl ? {baseC[idx], 1'b0} : {1'b0, baseC[idx]};
    rdVal     = stb.regSel ? (cntScaled - prog[idx]) : (curA[idx] + prog[idx]);
    rdShift   = rdVal >> (POS_W'(stb.ctl) + (stb.bytePtr ? POS_W'(BYTE_W) : '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        baseA[i] <= '0;
        baseC[i] <= '0;
        curA[i]  <= '0;
        prog[i]  <= '0;
      end
      rdData <= '0;
    end else begin
      if (anyWr) begin
        if (stb.regSel) baseC[idx] <= newBase;
        else            baseA[idx] <= newBase;
      end
      if (progWr)
        prog[progChan] <= progVal;
      if (stb.reload) begin
        curA[idx] <= stb.ctl ? {addrSrc, 1'b0} : {1'b0, addrSrc};
        prog[idx] <= '0;
      end
      if (stb.rdEn)
        rdData <= rdShift[BYTE_W-1:0];
    end
  end

  // R12: read data only moves on a read
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.rdEn |=> $stable(rdData));

  // R6: a reload zeroes the channel's progress, beating a progress update
  a_r6_reload_prog: assert property (@(posedge clk) disable iff (rst)
    stb.reload |=> prog[$past(idx)] == '0);

  // R6: on controller 1 the reloaded address is always even
  a_r6_ctl1_even: assert property (@(posedge clk) disable iff (rst)
    (stb.reload && stb.ctl) |=> !curA[$past(idx)][0]);
endmodule

// File: rtl/dmaregs_top.sv
module dmaregs_top
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctlSel,
  input  logic [PORT_W-1:0] port,
  input  logic              ioWr,
  input  logic              ioWord,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              ioRd,
  input  logic              clrPtr,
  input  logic              mstRst,
  input  logic              progWr,
  input  logic [CHAN_W:0]   progChan,
  input  logic [ADDR_W:0]   progVal,
  output logic [7:0]        rdData
);
  regStb_t stb;

  dmaregs_ctrl #(.PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctlSel(ctlSel), .port(port),
    .ioWr(ioWr), .ioWord(ioWord), .ioRd(ioRd),
    .clrPtr(clrPtr), .mstRst(mstRst), .stb(stb)
  );

  dmaregs_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData),
    .progWr(progWr), .progChan(progChan), .progVal(progVal),
    .rdData(rdData)
  );
endmodule

// File: tb/dmaregs_top_bench.sv
module dmaregs_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctlSel = 1'b0;
  logic [3:0]  port = '0;
  logic        ioWr = 1'b0, ioWord = 1'b0, ioRd = 1'b0;
  logic [15:0] wrData = '0;
  logic        clrPtr = 1'b0, mstRst = 1'b0, progWr = 1'b0;
  logic [2:0]  progChan = '0;
  logic [16:0] progVal = '0;
  logic [7:0]  rdData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dmaregs_top u_dmaregs_top (
    .clk(clk), .rst(rst), .ctlSel(ctlSel), .port(port),
    .ioWr(ioWr), .ioWord(ioWord), .wrData(wrData), .ioRd(ioRd),
    .clrPtr(clrPtr), .mstRst(mstRst), .progWr(progWr),
    .progChan(progChan), .progVal(progVal), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ioWr = 0; ioWord = 0; ioRd = 0; clrPtr = 0; mstRst = 0; progWr = 0;
  endtask

  task automatic wrB(input logic c, input logic [3:0] p, input logic [7:0] d);
    @(negedge clk);
    ctlSel = c; port = p; wrData = {8'h00, d}; ioWr = 1; ioWord = 0;
    idle();
  endtask

  task automatic wrW(input logic c, input logic [3:0] p, input logic [15:0] d);
    @(negedge clk);
    ctlSel = c; port = p; wrData = d; ioWr = 1; ioWord = 1;
    idle();
  endtask

  task automatic rdChk(input logic c, input logic [3:0] p, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ctlSel = c; port = p; ioRd = 1;
    idle();
    chk(tag, rdData, exp);
  endtask

  task automatic clr(input logic c, input logic master);
    @(negedge clk);
    ctlSel = c; if (master) mstRst = 1; else clrPtr = 1;
    idle();
  endtask

  task automatic prg(input logic [2:0] ch, input logic [16:0] v);
    @(negedge clk);
    progChan = ch; progVal = v; progWr = 1;
    idle();
  endtask

  task automatic t_reset();
    chk("R1 rdData after reset", rdData, 8'h00);
    rdChk(0, 4'd6, 8'h00, "R1 chan3 addr zero");
    rdChk(0, 4'd7, 8'h00, "R1 chan3 count zero");
  endtask

  task automatic t_ctl0_bytes();
    clr(0, 1);
    wrB(0, 4'd2, 8'h34);
    rdChk(0, 4'd2, 8'h00, "R4 low write no reload hi");
    rdChk(0, 4'd2, 8'h00, "R4 low write no reload lo");
    wrB(0, 4'd2, 8'h12);
    rdChk(0, 4'd2, 8'h34, "R2 R4 reloaded lo");
    rdChk(0, 4'd2, 8'h12, "R2 R4 reloaded hi");
    wrW(0, 4'd3, 16'h0100);
    rdChk(0, 4'd3, 8'h00, "R5 word count lo");
    rdChk(0, 4'd3, 8'h01, "R5 word count hi");
    prg(3'd1, 17'd5);
    rdChk(0, 4'd2, 8'h39, "R8 addr+prog lo");
    rdChk(0, 4'd2, 8'h12, "R8 addr+prog hi");
    rdChk(0, 4'd3, 8'hFB, "R9 count-prog lo");
    rdChk(0, 4'd3, 8'h00, "R9 count-prog hi");
  endtask

  task automatic t_ctl1();
    clr(1, 1);
    wrW(1, 4'd8, 16'h4000);
    rdChk(1, 4'd9, 8'h00, "R3 R6 ctl1 addr lo");
    rdChk(1, 4'd9, 8'h40, "R3 R6 ctl1 addr hi");
    prg(3'd6, 17'h00102);
    rdChk(1, 4'd8, 8'h81, "R8 ctl1 addr+prog lo");
    rdChk(1, 4'd8, 8'h40, "R8 ctl1 addr+prog hi");
    wrB(1, 4'd10, 8'h10);
    wrB(1, 4'd11, 8'h00);
    rdChk(1, 4'd10, 8'h10, "R3 R9 ctl1 count lo");
    rdChk(1, 4'd10, 8'h00, "R9 ctl1 count hi");
    rdChk(1, 4'd8, 8'h00, "R6 prog cleared lo");
    rdChk(1, 4'd8, 8'h40, "R6 prog cleared hi");
  endtask

  task automatic t_indep();
    clr(0, 0); clr(1, 0);
    wrB(0, 4'd0, 8'hAA);
    rdChk(1, 4'd8, 8'h00, "R7 ctl1 own ptr low");
    rdChk(0, 4'd2, 8'h12, "R7 ctl0 ptr still high");
  endtask

  task automatic t_clear();
    wrB(0, 4'd0, 8'h77);
    clr(0, 0);
    rdChk(0, 4'd2, 8'h39, "R11 clrPtr low byte");
    @(negedge clk);
    ctlSel = 0; port = 4'd2; ioRd = 1; clrPtr = 1;
    idle();
    chk("R11 read with clear uses high", rdData, 8'h12);
    rdChk(0, 4'd2, 8'h39, "R11 clear overrides toggle");
    clr(0, 1);
    rdChk(0, 4'd2, 8'h39, "R11 mstRst low byte");
  endtask

  task automatic t_prog();
    clr(0, 0);
    @(negedge clk);
    ctlSel = 0; port = 4'd0; wrData = 16'h0050; ioWr = 1; ioWord = 1;
    progChan = 3'd0; progVal = 17'd7; progWr = 1;
    idle();
    rdChk(0, 4'd0, 8'h50, "R10 reload beats progress");
    prg(3'd0, 17'd7);
    rdChk(0, 4'd0, 8'h00, "R10 progress hi");
    rdChk(0, 4'd0, 8'h57, "R10 progress lo");
    idle(); idle(); idle();
    chk("R12 rdData held", rdData, 8'h57);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ctl0_bytes();
    t_ctl1();
    t_indep();
    t_clear();
    t_prog();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule